// File: doc/BRIEF.md
# Scatter-Gather List Walker

This block walks a chain of 16-byte scatter-gather entries in memory and turns each data entry into one transfer request for a data mover. A walk starts from a command block address. The first table sits inline in that block, right after a 32-byte header, and holds at most six entries. Any entry can redirect the walk into a further table elsewhere in memory. An entry can also ask for incoming data to be dropped instead of stored.

The walker reads each entry as four 32-bit words through a simple request/valid read port. It decodes the flags and either jumps to a new table or presents the buffer address and byte count on a valid/ready request port. It then waits for the mover's completion strobe before it fetches the next entry. A walk ends with a one-cycle `done` pulse. It can instead end with a one-cycle `err` pulse and a numeric code, raised for a misaligned table address, a fault reported during an entry fetch, or device data still pending when the entries are used up.

Top module: `sg_walker`

## Requirements
- R1: While reset is asserted and after it is released, `rd_req`, `xfer_valid`, `done` and `err` are low and `err_code` is 0.
- R2: An accepted start fetches the first entry at `tbl_base + 32` as four 32-bit reads at byte offsets 0, 4, 8 and 12, in that order. Word 0 is address bits 31:0, word 1 is address bits 63:32, word 2 is the byte count and word 3 is the flags. `rd_addr` holds until `rd_valid` or a fault strobe arrives.
- R3: A data entry produces one request with `xfer_addr` = {word 1, word 0} and `xfer_len` = word 2, held until `xfer_ready`. The following entry, 16 bytes further on, is fetched only after `xfer_done`.
- R4: An entry with flag bit 31 set is the last entry. After its `xfer_done` with `xfer_left` low, `done` pulses for one cycle and no further reads occur.
- R5: An entry with flag bit 30 set issues no transfer. The next entry is fetched from the address in words 0 and 1, with no header offset. Bit 30 takes precedence over bit 31.
- R6: An entry with flag bit 29 set issues a request with `xfer_discard` high and `xfer_addr` 0, whatever its address words hold.
- R7: The sixth entry of the inline table ends the walk as if bit 31 were set. The seventh word group is never read.
- R8: If `xfer_left` is high with `xfer_done` of the last entry, the walk ends with error code 7 when `dir_wr` was 1 at start, and code 8 when it was 0. `xfer_left` on any other entry is ignored.
- R9: A table base or link address whose three low bits are not zero ends the walk with code 16, and no read is made at that address.
- R10: A fault strobe during an entry fetch ends the walk with code 17 (`flt_tgt`), 18 (`flt_mst`) or 19 (`flt_par`). When more than one strobe is high, the lowest code wins.
- R11: `err` is a one-cycle pulse. `err_code` keeps its value until the next accepted start, which clears it to 0.
- R12: A start raised while a walk is in progress is ignored, and the running walk completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| tbl_base | input | 64 | Command block address |
| dir_wr | input | 1 | 1 = write direction, 0 = read direction |
| rd_req | output | 1 | Entry word read request |
| rd_addr | output | 64 | Entry word byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data word |
| flt_tgt | input | 1 | Target abort during fetch |
| flt_mst | input | 1 | Master abort during fetch |
| flt_par | input | 1 | Parity error during fetch |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_addr | output | 64 | Buffer address of the request |
| xfer_len | output | 32 | Byte count of the request |
| xfer_discard | output | 1 | Drop incoming data for this request |
| xfer_done | input | 1 | Current transfer finished |
| xfer_left | input | 1 | Device data still pending at `xfer_done` |
| done | output | 1 | Walk completed (pulse) |
| err | output | 1 | Walk aborted (pulse) |
| err_code | output | 6 | Code of the last abort, 0 otherwise |

## Verification
The bench targets the six-entry inline limit: a walker that ignored the limit would read a seventh entry and issue an extra transfer. It sets both link and terminate on one entry, and a walker that honoured terminate first would stop early. It raises `xfer_left` on non-last entries, which a careless walker would turn into a spurious underrun or overrun. It also misaligns a link target rather than only the base, and raises two fault strobes together to expose a wrong priority. Further cases are a second start in mid-walk, which must not restart the walk, and a stalled `xfer_ready`, during which the request must stay unchanged.

// File: rtl/sg_walker.sv
module sg_walker #(
  parameter int INLINE_N    = 6,
  parameter int HDR_BYTES   = 32,
  parameter int ALIGN_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] tbl_base,
  input  logic        dir_wr,
  output logic        rd_req,
  output logic [63:0] rd_addr,
  input  logic        rd_valid,
  input  logic [31:0] rd_data,
  input  logic        flt_tgt,
  input  logic        flt_mst,
  input  logic        flt_par,
  output logic        xfer_valid,
  input  logic        xfer_ready,
  output logic [63:0] xfer_addr,
  output logic [31:0] xfer_len,
  output logic        xfer_discard,
  input  logic        xfer_done,
  input  logic        xfer_left,
  output logic        done,
  output logic        err,
  output logic [5:0]  err_code
);
  localparam int ENT_BYTES = 16;
  localparam int ALW = $clog2(ALIGN_BYTES);
  localparam int IW  = $clog2(INLINE_N + 1);
  localparam logic [5:0] C_UNDER = 6'd7, C_OVER = 6'd8, C_ALIGN = 6'd16,
                         C_TGT = 6'd17, C_MST = 6'd18, C_PAR = 6'd19;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [63:0]   ent_addr, buf_addr;
  logic [31:0]   buf_len;
  logic [1:0]    word;
  logic [IW-1:0] idx;
  logic          inl, last_r, disc_r, wr_dir;

  wire       fault      = flt_tgt | flt_mst | flt_par;
  wire [5:0] fault_code = flt_tgt ? C_TGT : (flt_mst ? C_MST : C_PAR);
  wire       base_bad   = |tbl_base[ALW-1:0];
  wire       link_bad   = |buf_addr[ALW-1:0];
  wire       inl_end    = inl && (idx == IW'(INLINE_N - 1));

  assign rd_req       = (st == S_FETCH);
  assign rd_addr      = ent_addr + 64'({word, 2'b00});
  assign xfer_valid   = (st == S_ISSUE);
  assign xfer_addr    = disc_r ? 64'd0 : buf_addr;
  assign xfer_len     = buf_len;
  assign xfer_discard = disc_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ent_addr <= '0;
      buf_addr <= '0;
      buf_len  <= '0;
      word     <= '0;
      idx      <= '0;
      inl      <= 1'b0;
      last_r   <= 1'b0;
      disc_r   <= 1'b0;
      wr_dir   <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          wr_dir <= dir_wr;
          if (base_bad) begin
            err_code <= C_ALIGN;
            err      <= 1'b1;
          end else begin
            err_code <= '0;
            ent_addr <= tbl_base + 64'(HDR_BYTES);
            inl      <= 1'b1;
            idx      <= '0;
            word     <= '0;
            st       <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (fault) begin
            err_code <= fault_code;
            err      <= 1'b1;
            st       <= S_IDLE;
          end else if (rd_valid) begin
            word <= word + 2'd1;
            case (word)
              2'd0: buf_addr[31:0]  <= rd_data;
              2'd1: buf_addr[63:32] <= rd_data;
              2'd2: buf_len         <= rd_data;
              default: begin
                if (rd_data[30]) begin
                  if (link_bad) begin
                    err_code <= C_ALIGN;
                    err      <= 1'b1;
                    st       <= S_IDLE;
                  end else begin
                    ent_addr <= buf_addr;
                    inl      <= 1'b0;
                    idx      <= '0;
                  end
                end else begin
                  disc_r <= rd_data[29];
                  last_r <= rd_data[31] | inl_end;
                  st     <= S_ISSUE;
                end
              end
            endcase
          end
        end
        S_ISSUE: if (xfer_ready) st <= S_WAIT;
        S_WAIT: if (xfer_done) begin
          if (last_r) begin
            if (xfer_left) begin
              err_code <= wr_dir ? C_UNDER : C_OVER;
              err      <= 1'b1;
            end else begin
              done <= 1'b1;
            end
            st <= S_IDLE;
          end else begin
            ent_addr <= ent_addr + 64'(ENT_BYTES);
            idx      <= idx + IW'(1);
            word     <= '0;
            st       <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_walker_chk.sv
module sg_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        rd_req,
  input logic [63:0] rd_addr,
  input logic        rd_valid,
  input logic        flt_tgt,
  input logic        flt_mst,
  input logic        flt_par,
  input logic        xfer_valid,
  input logic        xfer_ready,
  input logic [63:0] xfer_addr,
  input logic [31:0] xfer_len,
  input logic        xfer_done,
  input logic        xfer_left,
  input logic        done,
  input logic        err,
  input logic [5:0]  err_code
);
  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid && !(flt_tgt || flt_mst || flt_par) |=> rd_req && $stable(rd_addr));

  assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));

  assert_done_after_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(xfer_done) && !$past(xfer_left));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_end_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_left_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err && (err_code == 6'd7 || err_code == 6'd8) |-> $past(xfer_done && xfer_left));

  assert_code_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_code == 6'd7 || err_code == 6'd8 || err_code == 6'd16 ||
             err_code == 6'd17 || err_code == 6'd18 || err_code == 6'd19));

  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> err || $stable(err_code));
endmodule

bind sg_walker sg_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .flt_tgt(flt_tgt), .flt_mst(flt_mst), .flt_par(flt_par),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
  .xfer_len(xfer_len), .xfer_done(xfer_done), .xfer_left(xfer_left),
  .done(done), .err(err), .err_code(err_code)
);

// File: tb/sim_sg_walker.sv
module sim_sg_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TRM = 32'h8000_0000, LNK = 32'h4000_0000, DRD = 32'h2000_0000;
  // row: sid[11:8] dir[7] left[6] code[5:0]
  localparam logic [11:0] VEC [6] = '{12'h000, 12'h0C7, 12'h048, 12'h100, 12'h280, 12'h2C7};

  logic clk = 0, rst_n = 0, start = 0, dir_wr = 0;
  logic [63:0] tbl_base = '0;
  logic rd_valid = 0, flt_tgt = 0, flt_mst = 0, flt_par = 0;
  logic [31:0] rd_data = '0;
  logic xfer_ready = 0, xfer_done = 0, xfer_left = 0;
  logic rd_req, xfer_valid, xfer_discard, done, err;
  logic [63:0] rd_addr, xfer_addr;
  logic [31:0] xfer_len;
  logic [5:0] err_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_walker u0 (.*);

  logic [31:0] mem [0:1023];
  logic [63:0] lx_addr [0:15], ex_addr [0:15], lr_addr [0:63];
  logic [31:0] lx_len [0:15], ex_len [0:15];
  logic lx_disc [0:15], ex_disc [0:15];
  int nx = 0, ne = 0, nr = 0, stall = 0, scnt = 0, dcnt = 0, fault_at = -1;
  logic [2:0] fault_bits = 3'b000;
  logic left_knob = 0, got_done = 0, got_err = 0;
  logic [5:0] got_code = '0;
  int errors = 0, checks = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (done) got_done = 1;
    if (err) begin got_err = 1; got_code = err_code; end
    {flt_tgt, flt_mst, flt_par} = 3'b000;
    xfer_done = 0;
    if (rd_valid) rd_valid = 0;
    else if (rd_req) begin
      if (fault_at == nr) begin
        {flt_tgt, flt_mst, flt_par} = fault_bits;
        fault_at = -1;
      end else begin
        rd_data = mem[rd_addr[11:2]];
        rd_valid = 1;
        if (nr < 64) lr_addr[nr] = rd_addr;
        nr++;
      end
    end
    if (dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) begin xfer_done = 1; xfer_left = left_knob; end
    end
    if (xfer_ready) xfer_ready = 0;
    else if (xfer_valid) begin
      if (scnt < stall) scnt++;
      else begin
        xfer_ready = 1; scnt = 0; dcnt = 2;
        if (nx < 16) begin
          lx_addr[nx] = xfer_addr; lx_len[nx] = xfer_len; lx_disc[nx] = xfer_discard;
        end
        nx++;
      end
    end
  end

  task automatic put(input int a, input logic [31:0] hi, lo, len, flags);
    mem[a/4] = lo; mem[a/4+1] = hi; mem[a/4+2] = len; mem[a/4+3] = flags;
  endtask

  task automatic ex(input logic [63:0] a, input logic [31:0] len, input logic disc);
    ex_addr[ne] = a; ex_len[ne] = len; ex_disc[ne] = disc; ne++;
  endtask

  task automatic build(input int sid);
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    ne = 0;
    case (sid)
      0: begin
        put(32'h120, 1, 32'h1000, 32'h200, 0);
        put(32'h130, 2, 32'h2000, 32'h201, 0);
        put(32'h140, 3, 32'h3000, 32'h202, TRM);
        ex({32'd1, 32'h1000}, 32'h200, 0);
        ex({32'd2, 32'h2000}, 32'h201, 0);
        ex({32'd3, 32'h3000}, 32'h202, 0);
      end
      1: begin
        put(32'h120, 5, 32'h5000, 32'h40, 0);
        put(32'h130, 0, 32'h300, 0, LNK | TRM);
        put(32'h300, 6, 32'h6000, 32'h80, DRD);
        put(32'h310, 7, 32'h7000, 32'h81, TRM);
        ex({32'd5, 32'h5000}, 32'h40, 0);
        ex(64'd0, 32'h80, 1);
        ex({32'd7, 32'h7000}, 32'h81, 0);
      end
      2: begin
        for (int i = 0; i < 7; i++) begin
          put(32'h120 + 16*i, 32'(i + 8), 32'h8000 + 32'(i*256), 32'h10 + 32'(i), 0);
          if (i < 6) ex({32'(i + 8), 32'h8000 + 32'(i*256)}, 32'h10 + 32'(i), 0);
        end
      end
      default: begin
        put(32'h120, 1, 32'h1000, 32'h20, 0);
        put(32'h130, 0, 32'h304, 0, LNK);
        ex({32'd1, 32'h1000}, 32'h20, 0);
      end
    endcase
  endtask

  task automatic go(input logic [63:0] b, input logic d);
    nx = 0; nr = 0; got_done = 0; got_err = 0; got_code = '0;
    @(negedge clk);
    start = 1; tbl_base = b; dir_wr = d;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_walk();
    for (int i = 0; i < 600 && !got_done && !got_err; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_walk(input string tag, input logic [5:0] code);
    chk({tag, " count"}, 64'(nx), 64'(ne));
    for (int i = 0; i < ne && i < nx; i++) begin
      chk({tag, " addr"}, lx_addr[i], ex_addr[i]);
      chk({tag, " len"}, 64'(lx_len[i]), 64'(ex_len[i]));
      chk({tag, " discard"}, 64'(lx_disc[i]), 64'(ex_disc[i]));
    end
    chk({tag, " done"}, 64'(got_done), 64'(code == 0));
    chk({tag, " err"}, 64'(got_err), 64'(code != 0));
    chk({tag, " code"}, 64'(err_code), 64'(code));
  endtask

  function automatic string row_tag(input int r);
    case (r)
      0: return "R3 R4 row0";
      1: return "R8 row1 write";
      2: return "R8 row2 read";
      3: return "R5 R6 row3";
      4: return "R7 row4";
      default: return "R7 R8 row5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rd_req", 64'(rd_req), 0);
    chk("R1 reset xfer_valid", 64'(xfer_valid), 0);
    chk("R1 reset pulses", 64'({done, err}), 0);
    chk("R1 reset code", 64'(err_code), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", 64'({rd_req, xfer_valid, done, err}), 0);

    for (int r = 0; r < 6; r++) begin
      build(int'(VEC[r][11:8]));
      left_knob = VEC[r][6];
      go(64'h100, VEC[r][7]);
      finish_walk();
      check_walk(row_tag(r), VEC[r][5:0]);
      if (r == 0) begin
        for (int k = 0; k < 5; k++) chk("R2 fetch order", lr_addr[k], 64'h120 + 64'(4*k));
        chk("R2 read count", 64'(nr), 12);
      end
      if (r == 4) chk("R7 no seventh fetch", 64'(nr), 24);
    end
    left_knob = 0;

    build(0); ne = 0;
    go(64'h104, 0); finish_walk();
    check_walk("R9 base misaligned", 6'd16);
    chk("R9 no read", 64'(nr), 0);

    build(3);
    go(64'h100, 0); finish_walk();
    check_walk("R9 link misaligned", 6'd16);

    build(0); ne = 1; fault_at = 5; fault_bits = 3'b100;
    go(64'h100, 0); finish_walk();
    check_walk("R10 target abort", 6'd17);

    build(0); ne = 0; fault_at = 0; fault_bits = 3'b011;
    go(64'h100, 0); finish_walk();
    check_walk("R10 master over parity", 6'd18);

    build(0); ne = 2; fault_at = 9; fault_bits = 3'b001;
    go(64'h100, 0); finish_walk();
    check_walk("R10 parity", 6'd19);

    repeat (5) @(negedge clk);
    chk("R11 code holds", 64'(err_code), 19);
    build(0);
    go(64'h100, 0);
    chk("R11 start clears code", 64'(err_code), 0);
    finish_walk();
    check_walk("R11 walk after error", 6'd0);

    build(0);
    go(64'h100, 0);
    repeat (4) @(negedge clk);
    start = 1; tbl_base = 64'h104;
    @(negedge clk);
    start = 0;
    finish_walk();
    check_walk("R12 start while busy", 6'd0);

    build(1); stall = 3;
    go(64'h100, 1); finish_walk();
    check_walk("R3 stalled ready", 6'd0);
    stall = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule